// File: doc/BRIEF.md
# Low-Power Watchdog Timer with Wake

This block is a watchdog that runs from a slow, low-power tick of roughly 31 kHz. Every rising edge of `clk` is one tick of that source. The tick count passes through two dividers in series. The first is a prescaler with a choice of two ratios. The second is a postscaler whose ratio is a power of two, picked by a 4-bit code. When the postscaler reaches its terminal count, the watchdog has timed out.

What happens on a time-out depends on the power state. If the device is running normally, the block requests a device reset. If the device is asleep or idle, it requests a wake-up, and execution then continues after the power-save instruction. Every time-out also sets a sticky flag. Software has to clear that flag itself. A device reset does not clear it, so software can still read the flag to learn why the device was reset.

Several events restart both counters from zero:
- a device reset,
- a completed clock switch,
- entry into a power-save mode,
- an exit from a power-save mode,
- a software clear that arrives while the device is running.

When the watchdog is disabled, its counters stay at zero. While it is enabled, the block asks for its tick source to be kept running.

Top module: `lpwdt_top`

## Requirements
- R1: The prescaler divides the tick by 32 when `pre_long`=0 and by 128 when `pre_long`=1. Its count wraps to 0 after its last value.
- R2: Postscaler code n (0 to 15) selects a ratio of 2^n. After a restart at clock edge E, the time-out request appears at the output registers at edge E + D·2^n, where D is 32 or 128. Both counters then restart by themselves, so the next time-out follows another D·2^n ticks later.
- R3: A time-out while `lp_mode`=0 drives `reset_req` high for exactly one cycle. `wake_req` stays low.
- R4: The counters keep running while `lp_mode`=1. A time-out in that state drives `wake_req` high for exactly one cycle. `reset_req` stays low.
- R5: Each of these restarts both counters from zero: `rst`, `clk_sw_done`, `pwr_save` and `lp_exit`.
- R6: `clr_wdt` restarts both counters when `lp_mode`=0. It has no effect when `lp_mode`=1.
- R7: A restart that is sampled at the same edge as the terminal count wins. No request is produced, and the next time-out comes a full period later.
- R8: `timeout_flag` is set on every time-out and is cleared only by `flag_clr`. If a time-out and `flag_clr` occur at the same edge, the flag stays set. `rst` leaves the flag unchanged.
- R9: When `wdt_en`=0, the counters are held at zero and no request is produced. `src_en` follows `wdt_en`. Once the watchdog is enabled again, it counts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-power watchdog tick; one edge per tick |
| rst | input | 1 | Synchronous active-high device reset |
| wdt_en | input | 1 | Watchdog enable |
| pre_long | input | 1 | Prescaler select: 0 divides by 32, 1 divides by 128 |
| post_code | input | 4 | Postscaler code n, giving a ratio of 2^n |
| clr_wdt | input | 1 | Software clear strobe, honoured only while running |
| pwr_save | input | 1 | Power-save entry strobe |
| clk_sw_done | input | 1 | Clock-switch-complete strobe |
| lp_exit | input | 1 | Sleep/idle exit strobe |
| lp_mode | input | 1 | 1 while the device is asleep or idle |
| flag_clr | input | 1 | Software clear of the time-out flag |
| src_en | output | 1 | Keeps the low-power tick source running |
| reset_req | output | 1 | One-cycle device-reset request |
| wake_req | output | 1 | One-cycle wake request |
| timeout_flag | output | 1 | Sticky time-out flag |

## Verification
A request is due exactly D·2^n edges after the edge that samples a restart: there are D·2^n − 1 edges of counting, plus one edge into the output register. The bench therefore pulses a restart, counts rising edges, samples the outputs at each following falling edge, and compares the edge count at which the first request appears with the expected period.

Two other results are due one edge after their stimulus. A flag clear, and a restart placed on the terminal edge, are both checked at the falling edge right after the edge that samples them. Re-enabling is counted from the last disabled edge, which is where the counters were last held at zero.

// File: rtl/lpwdt_pkg.sv
package lpwdt_pkg;

  // Events that restart the divider chain
  typedef struct packed {
    logic dev_reset;
    logic disabled;
    logic clk_switch;
    logic save_entry;
    logic save_exit;
    logic sw_clear;
  } restart_src_t;

  function automatic logic any_restart(input restart_src_t s);
    return s.dev_reset | s.disabled | s.clk_switch |
           s.save_entry | s.save_exit | s.sw_clear;
  endfunction

endpackage

// File: rtl/lpwdt_restart.sv
module lpwdt_restart
  import lpwdt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wdt_en,
  input  logic lp_mode,
  input  logic clr_wdt,
  input  logic pwr_save,
  input  logic clk_sw_done,
  input  logic lp_exit,
  output logic restart
);

  restart_src_t src;

  always_comb begin
    src.dev_reset  = rst;
    src.disabled   = ~wdt_en;
    src.clk_switch = clk_sw_done;
    src.save_entry = pwr_save;
    src.save_exit  = lp_exit;
    // software clear executes only while the core runs
    src.sw_clear   = clr_wdt & ~lp_mode;
  end

  assign restart = any_restart(src);

  // R6: a clear in low-power mode alone must not restart
  assert_sleep_clear_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (lp_mode && clr_wdt && wdt_en && !clk_sw_done && !pwr_save && !lp_exit) |-> !restart);

endmodule

// File: rtl/lpwdt_prescaler.sv
module lpwdt_prescaler #(
  parameter int SHORT_LOG2 = 5,
  parameter int LONG_LOG2  = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic pre_long,
  output logic pre_tc
);

  localparam int PRE_W = LONG_LOG2;
  localparam logic [PRE_W-1:0] LIM_SHORT = PRE_W'((1 << SHORT_LOG2) - 1);
  localparam logic [PRE_W-1:0] LIM_LONG  = PRE_W'((1 << LONG_LOG2) - 1);

  logic [PRE_W-1:0] cnt;
  logic [PRE_W-1:0] lim;

  assign lim    = pre_long ? LIM_LONG : LIM_SHORT;
  assign pre_tc = (cnt >= lim);

  always_ff @(posedge clk) begin
    if (restart)     cnt <= '0;
    else if (pre_tc) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  // R1: terminal prescaler count wraps to zero
  assert_pre_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    (pre_tc && !restart) |=> (cnt == '0));

  // R5: restart empties the prescaler
  assert_pre_restart_R5: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt == '0));

endmodule

// File: rtl/lpwdt_postscaler.sv
module lpwdt_postscaler #(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              pre_tc,
  input  logic [CODE_W-1:0] code,
  output logic              post_tc
);

  localparam int POST_W = (1 << CODE_W) - 1;

  logic [POST_W-1:0] cnt;
  logic [POST_W-1:0] lim;

  // 2^code - 1 as a right-shifted all-ones mask
  assign lim     = {POST_W{1'b1}} >> (POST_W - int'(code));
  assign post_tc = pre_tc && (cnt >= lim);

  always_ff @(posedge clk) begin
    if (restart)      cnt <= '0;
    else if (post_tc) cnt <= '0;
    else if (pre_tc)  cnt <= cnt + 1'b1;
  end

  // R2: each prescaler period below the limit advances the postscaler by one
  assert_post_step_R2: assert property (@(posedge clk) disable iff (rst)
    (pre_tc && !post_tc && !restart) |=> (cnt == $past(cnt) + 1'b1));

  // R2: after terminal count the postscaler restarts
  assert_post_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (post_tc && !restart) |=> (cnt == '0));

endmodule

// File: rtl/lpwdt_event.sv
module lpwdt_event (
  input  logic clk,
  input  logic rst,
  input  logic timeout,
  input  logic lp_mode,
  input  logic flag_clr,
  output logic reset_req,
  output logic wake_req,
  output logic timeout_flag
);

  always_ff @(posedge clk) begin
    if (rst) begin
      reset_req <= 1'b0;
      wake_req  <= 1'b0;
    end else begin
      reset_req <= timeout & ~lp_mode;
      wake_req  <= timeout & lp_mode;
    end
  end

  // sticky cause flag survives device reset; set beats clear
  always_ff @(posedge clk) begin
    if (timeout)       timeout_flag <= 1'b1;
    else if (flag_clr) timeout_flag <= 1'b0;
  end

  // R8: the flag only falls on an explicit clear
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (timeout_flag && !flag_clr) |=> timeout_flag);

  // R3/R4: reset and wake requests never coincide
  assert_req_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    !(reset_req && wake_req));

endmodule

// File: rtl/lpwdt_top.sv
module lpwdt_top #(
  parameter int SHORT_LOG2 = 5,
  parameter int LONG_LOG2  = 7,
  parameter int CODE_W     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wdt_en,
  input  logic              pre_long,
  input  logic [CODE_W-1:0] post_code,
  input  logic              clr_wdt,
  input  logic              pwr_save,
  input  logic              clk_sw_done,
  input  logic              lp_exit,
  input  logic              lp_mode,
  input  logic              flag_clr,
  output logic              src_en,
  output logic              reset_req,
  output logic              wake_req,
  output logic              timeout_flag
);

  logic restart;
  logic pre_tc;
  logic post_tc;
  logic timeout;

  assign src_en = wdt_en;

  lpwdt_restart u_restart (
    .clk         (clk),
    .rst         (rst),
    .wdt_en      (wdt_en),
    .lp_mode     (lp_mode),
    .clr_wdt     (clr_wdt),
    .pwr_save    (pwr_save),
    .clk_sw_done (clk_sw_done),
    .lp_exit     (lp_exit),
    .restart     (restart)
  );

  lpwdt_prescaler #(
    .SHORT_LOG2 (SHORT_LOG2),
    .LONG_LOG2  (LONG_LOG2)
  ) u_pre (
    .clk      (clk),
    .rst      (rst),
    .restart  (restart),
    .pre_long (pre_long),
    .pre_tc   (pre_tc)
  );

  lpwdt_postscaler #(
    .CODE_W (CODE_W)
  ) u_post (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .pre_tc  (pre_tc),
    .code    (post_code),
    .post_tc (post_tc)
  );

  // a restart on the terminal edge suppresses the time-out
  assign timeout = post_tc & ~restart;

  lpwdt_event u_evt (
    .clk          (clk),
    .rst          (rst),
    .timeout      (timeout),
    .lp_mode      (lp_mode),
    .flag_clr     (flag_clr),
    .reset_req    (reset_req),
    .wake_req     (wake_req),
    .timeout_flag (timeout_flag)
  );

  // R3: reset request lasts one cycle
  assert_reset_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    reset_req |=> !reset_req);

  // R4: wake request lasts one cycle and follows a low-power cycle
  assert_wake_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    wake_req |=> !wake_req);
  assert_wake_in_lp_R4: assert property (@(posedge clk) disable iff (rst)
    wake_req |-> $past(lp_mode));

  // R7: a running-mode clear on any edge blocks a request on the next
  assert_clear_wins_R7: assert property (@(posedge clk) disable iff (rst)
    (clr_wdt && !lp_mode) |=> (!reset_req && !wake_req));

  // R9: disabled watchdog produces no request
  assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !wdt_en |=> (!reset_req && !wake_req));

endmodule

// File: tb/sim_lpwdt_top.sv
module sim_lpwdt_top;

  logic       clk = 1'b0;
  logic       rst;
  logic       wdt_en;
  logic       pre_long;
  logic [3:0] post_code;
  logic       clr_wdt;
  logic       pwr_save;
  logic       clk_sw_done;
  logic       lp_exit;
  logic       lp_mode;
  logic       flag_clr;
  logic       src_en;
  logic       reset_req;
  logic       wake_req;
  logic       timeout_flag;

  int nchk  = 0;
  int nfail = 0;
  int cyc   = 0;

  always #5 clk = ~clk;

  lpwdt_top u0 (
    .clk          (clk),
    .rst          (rst),
    .wdt_en       (wdt_en),
    .pre_long     (pre_long),
    .post_code    (post_code),
    .clr_wdt      (clr_wdt),
    .pwr_save     (pwr_save),
    .clk_sw_done  (clk_sw_done),
    .lp_exit      (lp_exit),
    .lp_mode      (lp_mode),
    .flag_clr     (flag_clr),
    .src_en       (src_en),
    .reset_req    (reset_req),
    .wake_req     (wake_req),
    .timeout_flag (timeout_flag)
  );

  // stimulus vector: config, restart source (0 clr_wdt, 1 clk_sw_done,
  // 2 pwr_save, 3 lp_exit), expected ticks to request, expected kind
  typedef struct packed {
    logic        pl;
    logic [3:0]  code;
    logic        lp;
    logic [1:0]  src;
    logic [15:0] ticks;
    logic        wake;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 4'd0, 1'b0, 2'd0, 16'd32,   1'b0},
    '{1'b0, 4'd1, 1'b0, 2'd1, 16'd64,   1'b0},
    '{1'b0, 4'd2, 1'b1, 2'd2, 16'd128,  1'b1},
    '{1'b0, 4'd3, 1'b0, 2'd3, 16'd256,  1'b0},
    '{1'b1, 4'd0, 1'b0, 2'd1, 16'd128,  1'b0},
    '{1'b1, 4'd1, 1'b1, 2'd1, 16'd256,  1'b1},
    '{1'b1, 4'd2, 1'b0, 2'd2, 16'd512,  1'b0},
    '{1'b1, 4'd3, 1'b1, 2'd3, 16'd1024, 1'b1},
    '{1'b0, 4'd4, 1'b0, 2'd0, 16'd512,  1'b0},
    '{1'b0, 4'd5, 1'b1, 2'd2, 16'd1024, 1'b1},
    '{1'b1, 4'd4, 1'b0, 2'd0, 16'd2048, 1'b0},
    '{1'b0, 4'd6, 1'b0, 2'd3, 16'd2048, 1'b0}
  };

  task automatic summary_and_end();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      nchk  = nchk + 1;
      nfail = nfail + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cyc);
      summary_and_end();
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    nchk = nchk + 1;
    if (!ok) begin
      nfail = nfail + 1;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // applies config and pulses one restart source; returns at the
  // falling edge after the sampling edge
  task automatic restart_with(input int s, input logic pl, input logic [3:0] pc, input logic lp);
    @(negedge clk);
    pre_long  = pl;
    post_code = pc;
    lp_mode   = lp;
    case (s)
      0: clr_wdt     = 1'b1;
      1: clk_sw_done = 1'b1;
      2: pwr_save    = 1'b1;
      default: lp_exit = 1'b1;
    endcase
    @(posedge clk);
    @(negedge clk);
    clr_wdt = 1'b0; clk_sw_done = 1'b0; pwr_save = 1'b0; lp_exit = 1'b0;
  endtask

  // counts rising edges until a request is seen at a falling edge
  task automatic measure(output int n, output logic r, output logic w);
    logic got;
    got = 1'b0;
    n = 0;
    while (!got && n < 5000) begin
      @(posedge clk);
      n = n + 1;
      @(negedge clk);
      if (reset_req || wake_req) got = 1'b1;
    end
    r = reset_req;
    w = wake_req;
  endtask

  initial begin
    int   n;
    logic r;
    logic w;

    rst = 1'b1; wdt_en = 1'b1; pre_long = 1'b0; post_code = 4'd0;
    clr_wdt = 1'b0; pwr_save = 1'b0; clk_sw_done = 1'b0; lp_exit = 1'b0;
    lp_mode = 1'b0; flag_clr = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0; flag_clr = 1'b0;

    // reset state
    check(reset_req == 1'b0, "R3 reset state reset_req", int'(reset_req), 0);
    check(wake_req == 1'b0, "R4 reset state wake_req", int'(wake_req), 0);
    check(timeout_flag == 1'b0, "R8 flag after clear", int'(timeout_flag), 0);
    check(src_en == 1'b1, "R9 src_en enabled", int'(src_en), 1);

    // vector table walk: R1 R2 R3 R4 R5
    for (int i = 0; i < NVEC; i++) begin
      restart_with(int'(VEC[i].src), VEC[i].pl, VEC[i].code, VEC[i].lp);
      measure(n, r, w);
      check(n == int'(VEC[i].ticks), "R1/R2 period", n, int'(VEC[i].ticks));
      check(w == VEC[i].wake && r == !VEC[i].wake, "R3/R4 request kind",
            int'({r, w}), int'({!VEC[i].wake, VEC[i].wake}));
    end

    // R3 one-cycle request, R2 automatic restart
    restart_with(1, 1'b0, 4'd0, 1'b0);
    measure(n, r, w);
    check(n == 32 && r, "R3 run timeout", n, 32);
    @(negedge clk);
    check(reset_req == 1'b0, "R3 single cycle", int'(reset_req), 0);
    measure(n, r, w);
    check(n == 31, "R2 automatic restart", n, 31);
    check(timeout_flag == 1'b1, "R8 flag set", int'(timeout_flag), 1);

    // R6: clr_wdt in run mode restarts
    restart_with(1, 1'b0, 4'd0, 1'b0);
    repeat (10) @(negedge clk);
    clr_wdt = 1'b1;
    @(posedge clk);
    @(negedge clk);
    clr_wdt = 1'b0;
    measure(n, r, w);
    check(n == 32 && r, "R6 clear in run mode", n, 32);

    // R6: clr_wdt in low-power mode ignored
    restart_with(1, 1'b0, 4'd0, 1'b1);
    repeat (10) @(negedge clk);
    clr_wdt = 1'b1;
    @(posedge clk);
    @(negedge clk);
    clr_wdt = 1'b0;
    measure(n, r, w);
    check(n == 21 && w, "R6 clear ignored in low power", n, 21);

    // R7: clear on the terminal edge wins
    restart_with(1, 1'b0, 4'd0, 1'b0);
    repeat (31) @(negedge clk);
    clr_wdt = 1'b1;
    @(posedge clk);
    @(negedge clk);
    clr_wdt = 1'b0;
    check(reset_req == 1'b0 && wake_req == 1'b0, "R7 no request on clear edge",
          int'({reset_req, wake_req}), 0);
    measure(n, r, w);
    check(n == 32, "R7 full period after clear", n, 32);

    // R8: flag clear pulse
    @(negedge clk);
    flag_clr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    flag_clr = 1'b0;
    check(timeout_flag == 1'b0, "R8 flag cleared", int'(timeout_flag), 0);

    // R8: set beats clear on the same edge
    restart_with(1, 1'b0, 4'd0, 1'b0);
    repeat (31) @(negedge clk);
    flag_clr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    flag_clr = 1'b0;
    check(reset_req == 1'b1, "R8 timeout on flag-clear edge", int'(reset_req), 1);
    check(timeout_flag == 1'b1, "R8 set wins over clear", int'(timeout_flag), 1);

    // R8: device reset keeps the flag; R5: reset restarts count
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(timeout_flag == 1'b1, "R8 flag survives reset", int'(timeout_flag), 1);
    rst = 1'b0;
    measure(n, r, w);
    check(n == 32, "R5 reset restarts count", n, 32);

    // R9: disabled watchdog is quiet and idle
    @(negedge clk);
    wdt_en = 1'b0;
    begin
      int seen;
      seen = 0;
      for (int k = 0; k < 300; k++) begin
        @(negedge clk);
        if (reset_req || wake_req) seen = seen + 1;
      end
      check(seen == 0, "R9 no request while disabled", seen, 0);
    end
    check(src_en == 1'b0, "R9 src_en disabled", int'(src_en), 0);
    wdt_en = 1'b1;
    measure(n, r, w);
    check(n == 32, "R9 counts from zero after enable", n, 32);
    check(src_en == 1'b1, "R9 src_en re-enabled", int'(src_en), 1);

    summary_and_end();
  end

endmodule